// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

The block forms a 32-bit effective address from up to three operands: a base value, an index value scaled by a power of two, and a signed displacement. Each register operand has an enable, so the base or the index can be omitted, in which case it contributes zero. The index is scaled by shifting only, by 1, 2, 4 or 8.

A request selects one of two destinations. In memory mode the address goes out on a memory-request port. In address-only mode the address goes out on a register-writeback port with a destination tag, and no memory request is raised. That mode serves as a non-destructive three-operand add. It also serves as a multiply by 2, 3, 4, 5, 8 or 9 when base and index carry the same value. An optional output register, on by default, adds one cycle of latency.

Top module: `eagen_top`

## Requirements
- R1: The address equals base + (index << scale_i) + disp modulo 2^32, with scale_i encoded 00=x1, 01=x2, 10=x4, 11=x8.
- R2: The displacement is two's complement, so 0xFFFFFFFC subtracts 4.
- R3: Sums wrap modulo 2^32 and no overflow indication exists (0xFFFFFFF0 + 0x20 gives 0x00000010).
- R4: When base_en_i is 0 the base contributes zero, and when index_en_i is 0 the index contributes zero.
- R5: A request with addr_only_i=1 raises wb_valid_o with wb_data_o equal to the address and wb_dest_o equal to dest_i, and never raises mem_req_valid_o.
- R6: A request with addr_only_i=0 raises mem_req_valid_o with mem_addr_o equal to the address, and never raises wb_valid_o.
- R7: With REG_OUT=1, results appear exactly one cycle after the request. A cycle without req_valid_i leaves both valid outputs low in the following cycle.
- R8: After reset, both valid outputs are low and mem_addr_o, wb_data_o and wb_dest_o are zero.
- R9: With base and index both enabled and equal to x, zero displacement and address-only mode, scales 00/01/10/11 produce 2x, 3x, 5x and 9x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| addr_only_i | input | 1 | 1: write address to a register, 0: memory request |
| base_en_i | input | 1 | Base operand enable |
| base_i | input | 32 | Base value |
| index_en_i | input | 1 | Index operand enable |
| index_i | input | 32 | Index value |
| scale_i | input | 2 | Index shift amount |
| disp_i | input | 32 | Signed displacement |
| dest_i | input | DEST_W | Destination register tag |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_addr_o | output | 32 | Memory request address |
| wb_valid_o | output | 1 | Writeback valid |
| wb_dest_o | output | DEST_W | Writeback destination tag |
| wb_data_o | output | 32 | Writeback data (address) |

## Verification
The hardest case to reach from the ports is a wrap of the three-way sum in which the scaled index itself loses high bits. In that case the shift carry and the final carry are both dropped, and random operands rarely line them up. Directed requests use an index with its top bits set at scale 11, a base near 2^32, and negative displacements. Back-to-back requests that alternate modes and are separated by idle cycles probe the one-cycle latency and the mutual exclusion of the two outputs.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned SCL_W  = 2;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic [SCL_W-1:0] {
    SCL_X1 = 2'b00,
    SCL_X2 = 2'b01,
    SCL_X4 = 2'b10,
    SCL_X8 = 2'b11
  } scale_e;
endpackage

// File: rtl/eagen_scale.sv
module eagen_scale
  import eagen_pkg::*;
(
  input  logic   en_i,
  input  addr_t  idx_i,
  input  scale_e scale_i,
  output addr_t  scaled_o
);
  addr_t gated;
  assign gated = en_i ? idx_i : '0;

  always_comb begin
    unique case (scale_i)
      SCL_X1:  scaled_o = gated;
      SCL_X2:  scaled_o = {gated[ADDR_W-2:0], 1'b0};
      SCL_X4:  scaled_o = {gated[ADDR_W-3:0], 2'b0};
      default: scaled_o = {gated[ADDR_W-4:0], 3'b0};
    endcase
  end
endmodule

// File: rtl/eagen_sum.sv
module eagen_sum
  import eagen_pkg::*;
(
  input  logic  base_en_i,
  input  addr_t base_i,
  input  addr_t scaled_i,
  input  addr_t disp_i,
  output addr_t sum_o
);
  addr_t base_g;
  assign base_g = base_en_i ? base_i : '0;
  // carries out of bit 31 are discarded
  assign sum_o  = base_g + scaled_i + disp_i;
endmodule

// File: rtl/eagen_stage.sv
module eagen_stage
  import eagen_pkg::*;
#(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned DEST_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              addr_only_i,
  input  addr_t             addr_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic              mem_valid_o,
  output logic              wb_valid_o,
  output addr_t             addr_o,
  output logic [DEST_W-1:0] dest_o
);
  logic mem_v, wb_v;
  assign mem_v = valid_i & ~addr_only_i;
  assign wb_v  = valid_i &  addr_only_i;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_valid_o <= 1'b0;
        wb_valid_o  <= 1'b0;
        addr_o      <= '0;
        dest_o      <= '0;
      end else begin
        mem_valid_o <= mem_v;
        wb_valid_o  <= wb_v;
        if (valid_i) begin
          addr_o <= addr_i;
          dest_o <= dest_i;
        end
      end
    end
  end else begin : g_comb
    assign mem_valid_o = mem_v;
    assign wb_valid_o  = wb_v;
    assign addr_o      = addr_i;
    assign dest_o      = dest_i;
  end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
  import eagen_pkg::*;
#(
  parameter bit          REG_OUT  = 1'b1,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned DEST_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              addr_only_i,
  input  logic              base_en_i,
  input  logic [31:0]       base_i,
  input  logic              index_en_i,
  input  logic [31:0]       index_i,
  input  logic [1:0]        scale_i,
  input  logic [31:0]       disp_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic              mem_req_valid_o,
  output logic [31:0]       mem_addr_o,
  output logic              wb_valid_o,
  output logic [DEST_W-1:0] wb_dest_o,
  output logic [31:0]       wb_data_o
);
  addr_t scaled, sum, addr_q;

  eagen_scale u_scale (
    .en_i    (index_en_i),
    .idx_i   (index_i),
    .scale_i (scale_e'(scale_i)),
    .scaled_o(scaled)
  );

  eagen_sum u_sum (
    .base_en_i(base_en_i),
    .base_i   (base_i),
    .scaled_i (scaled),
    .disp_i   (disp_i),
    .sum_o    (sum)
  );

  eagen_stage #(.REG_OUT(REG_OUT), .DEST_W(DEST_W)) u_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .addr_only_i(addr_only_i),
    .addr_i     (sum),
    .dest_i     (dest_i),
    .mem_valid_o(mem_req_valid_o),
    .wb_valid_o (wb_valid_o),
    .addr_o     (addr_q),
    .dest_o     (wb_dest_o)
  );

  assign mem_addr_o = addr_q;
  assign wb_data_o  = addr_q;
endmodule

// File: rtl/eagen_chk.sv
module eagen_chk #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned DEST_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              addr_only_i,
  input logic              base_en_i,
  input logic [31:0]       base_i,
  input logic              index_en_i,
  input logic [31:0]       index_i,
  input logic [1:0]        scale_i,
  input logic [31:0]       disp_i,
  input logic [DEST_W-1:0] dest_i,
  input logic              mem_req_valid_o,
  input logic [31:0]       mem_addr_o,
  input logic              wb_valid_o,
  input logic [DEST_W-1:0] wb_dest_o,
  input logic [31:0]       wb_data_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_valid_o && wb_valid_o));

  if (REG_OUT) begin : g_seq
    p_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && req_valid_i && addr_only_i |=> wb_valid_o && !mem_req_valid_o && wb_dest_o == $past(dest_i));
    p_mem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && req_valid_i && !addr_only_i |=> mem_req_valid_o && !wb_valid_o);
    p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !req_valid_i |=> !mem_req_valid_o && !wb_valid_o);
    p_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && req_valid_i |=> mem_addr_o ==
        ($past(base_en_i ? base_i : 32'd0) + ($past(index_en_i ? index_i : 32'd0) << $past(scale_i)) + $past(disp_i)));
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !req_valid_i |=> $stable(mem_addr_o));
  end
endmodule

bind eagen_top eagen_chk #(.REG_OUT(REG_OUT), .DEST_W(DEST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .addr_only_i(addr_only_i),
  .base_en_i(base_en_i), .base_i(base_i), .index_en_i(index_en_i), .index_i(index_i),
  .scale_i(scale_i), .disp_i(disp_i), .dest_i(dest_i), .mem_req_valid_o(mem_req_valid_o),
  .mem_addr_o(mem_addr_o), .wb_valid_o(wb_valid_o), .wb_dest_o(wb_dest_o), .wb_data_o(wb_data_o)
);

// File: tb/eagen_top_test.sv
`timescale 1ns/1ps
module eagen_top_test;
  localparam int DW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_v = 0, aonly = 0, ben = 0, ien = 0;
  logic [31:0]   base = 0, idx = 0, disp = 0;
  logic [1:0]    scl = 0;
  logic [DW-1:0] dst = 0;
  logic          mem_v, wb_v;
  logic [31:0]   mem_a, wb_d;
  logic [DW-1:0] wb_t;

  eagen_top uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .addr_only_i(aonly),
    .base_en_i(ben), .base_i(base), .index_en_i(ien), .index_i(idx),
    .scale_i(scl), .disp_i(disp), .dest_i(dst),
    .mem_req_valid_o(mem_v), .mem_addr_o(mem_a), .wb_valid_o(wb_v),
    .wb_dest_o(wb_t), .wb_data_o(wb_d)
  );

  typedef struct {
    bit          v;
    bit          ao;
    logic [31:0] a;
    logic [DW-1:0] d;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0;
  bit running = 0;

  function automatic logic [31:0] model(bit be, logic [31:0] b, bit ie, logic [31:0] i,
                                        logic [1:0] s, logic [31:0] d);
    logic [31:0] bb, ii;
    bb = be ? b : 32'd0;
    ii = ie ? i : 32'd0;
    return bb + (ii << s) + d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, bit ao, bit be, logic [31:0] b, bit ie, logic [31:0] i,
                       logic [1:0] s, logic [31:0] d, logic [DW-1:0] t);
    item_t it;
    @(negedge clk);
    req_v = 1; aonly = ao; ben = be; base = b; ien = ie; idx = i; scl = s; disp = d; dst = t;
    it.v = 1; it.ao = ao; it.a = model(be, b, ie, i, s, d); it.d = t; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    item_t it;
    @(negedge clk);
    req_v = 0; base = $urandom; idx = $urandom; disp = $urandom;
    it.v = 0; it.ao = 0; it.a = 0; it.d = 0; it.tag = "R7";
    q.push_back(it);
  endtask

  // monitor: outputs settle after posedge, sample 1 ns later
  initial begin
    forever begin
      @(posedge clk); #1;
      if (running && q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (!it.v) begin
          check({it.tag, " idle mem_v"}, {31'd0, mem_v}, 32'd0);
          check({it.tag, " idle wb_v"},  {31'd0, wb_v},  32'd0);
        end else if (it.ao) begin
          check({it.tag, " R5 wb_v"},  {31'd0, wb_v},  32'd1);
          check({it.tag, " R5 mem_v"}, {31'd0, mem_v}, 32'd0);
          check({it.tag, " R5 data"},  wb_d, it.a);
          check({it.tag, " R5 dest"},  {27'd0, wb_t}, {27'd0, it.d});
        end else begin
          check({it.tag, " R6 mem_v"}, {31'd0, mem_v}, 32'd1);
          check({it.tag, " R6 wb_v"},  {31'd0, wb_v},  32'd0);
          check({it.tag, " R6 addr"},  mem_a, it.a);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 mem_v", {31'd0, mem_v}, 32'd0);
    check("R8 wb_v",  {31'd0, wb_v},  32'd0);
    check("R8 addr",  mem_a, 32'd0);
    check("R8 data",  wb_d,  32'd0);
    check("R8 dest",  {27'd0, wb_t}, 32'd0);
    @(negedge clk); rst_n = 1;
    running = 1;

    // R1 every scale
    for (int s = 0; s < 4; s++)
      drive("R1", 0, 1, 32'h1000, 1, 32'h10, s[1:0], 32'h4, 5'd1);
    // R2 negative displacement
    drive("R2", 0, 1, 32'h2000, 0, 0, 2'b00, 32'hFFFFFFFC, 5'd2);
    drive("R2", 1, 1, 32'h0, 1, 32'h3, 2'b11, 32'hFFFFFF00, 5'd3);
    // R3 wrap, including shifted-out index bits
    drive("R3", 0, 1, 32'hFFFFFFF0, 0, 0, 2'b00, 32'h20, 5'd4);
    drive("R3", 1, 1, 32'hFFFF0000, 1, 32'hF000_0001, 2'b11, 32'h0001_0000, 5'd5);
    // R4 disabled operands
    drive("R4", 0, 0, 32'hDEAD_BEEF, 1, 32'h5, 2'b10, 32'h100, 5'd6);
    drive("R4", 1, 1, 32'h300, 0, 32'hCAFE_F00D, 2'b11, 32'h7, 5'd7);
    drive("R4", 0, 0, 32'h1234, 0, 32'h5678, 2'b01, 32'h0, 5'd8);
    // R9 same value as base and index
    for (int s = 0; s < 4; s++)
      drive("R9", 1, 1, 32'd1000, 1, 32'd1000, s[1:0], 32'd0, 5'd9);
    // R7 idle gaps between requests
    idle();
    drive("R7", 0, 1, 32'h40, 1, 32'h2, 2'b01, 32'h0, 5'd10);
    idle(); idle();
    drive("R7", 1, 1, 32'h80, 1, 32'h2, 2'b10, 32'h1, 5'd11);
    // random, all scales, both modes
    for (int n = 0; n < 400; n++) begin
      if (n % 13 == 0) idle();
      else drive("R1", $urandom_range(0, 1), $urandom_range(0, 1), $urandom,
                 $urandom_range(0, 1), $urandom, n[1:0], $urandom, DW'($urandom));
    end
    idle(); idle();
    while (q.size() > 0) @(posedge clk);
    #2;
    // explicit R9 values: 2x,3x,5x,9x of 1000 were checked via model; spot-check one
    check("R9 model 9x", model(1, 32'd1000, 1, 32'd1000, 2'b11, 0), 32'd9000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule